// File: doc/BRIEF.md
# Synchronized Access Retry Queue

This block sits in front of a single memory port. New memory requests from the issue logic pass through it. The memory side reports in the same cycle whether an access failed because the word's full/empty state was wrong. A failed request does not return to the issue logic. It is parked in a 16-entry queue and re-sent automatically. The issue logic therefore keeps issuing one new request per tick while retries are pending.

Retries share the port with new traffic at a programmable ratio. One retry slot is taken after every N new-request slots. When nothing new is offered, or when the queue is full, a retry may take any slot. Each parked entry carries a retry count. Each protection domain (16 of them) has its own retry limit register. A request that reaches its domain's limit is discarded, and a trap is raised for the stream that issued it. A successful retry returns its response tagged with the original stream id.

Top module: `sync_retry_queue`

## Requirements
- R1: After reset the queue is empty, `new_ready` is high and the memory port is idle when no new request is offered. Every domain limit resets to `LIM_RST`.
- R2: When no retry takes the slot, an offered new request is forwarded unchanged to the memory port with `mem_is_retry` low. If it succeeds, `rsp_valid` rises in the same cycle with its stream id, and `rsp_data` equals `mem_rdata`.
- R3: A new request that fails in a domain with a nonzero limit enters the queue with retry count 0. In that cycle it produces neither a response nor a trap, and it is re-sent later with the same stream, domain, address, mode and write data.
- R4: While a new request is offered and the queue is neither empty nor full, a retry takes the slot only when at least `retry_gap` new requests have been issued since the last retry. That counter saturates at 2^GW-1. With `retry_gap` = 0, a non-empty queue takes every slot.
- R5: With the queue non-empty and no new request offered, the slot always carries a retry.
- R6: Retries are sent from the queue head in arrival order. A retry that fails and stays under its limit moves to the tail with its count raised by one.
- R7: A retry that succeeds leaves the queue and raises `rsp_valid` with the original stream id and `mem_is_retry` high.
- R8: A retry that fails when its incremented count reaches the domain's limit leaves the queue. `trap_valid` is raised with its stream and domain, and the request is not re-sent. A limit of L thus allows L retries.
- R9: When the domain's limit is 0, a failing new request traps at once and is not queued.
- R10: When the queue holds `DEPTH` entries, `new_ready` is low and the slot goes to a retry.
- R11: A write on the configuration port sets the limit of one domain, and that limit applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retry_gap | input | GW | New-request slots required between retries |
| cfg_we | input | 1 | Domain limit write strobe |
| cfg_domain | input | DMW | Domain whose limit is written |
| cfg_limit | input | LW | Limit value written |
| new_valid | input | 1 | New request offered |
| new_ready | output | 1 | New request accepted this cycle |
| new_stream | input | SW | Issuing stream id |
| new_domain | input | DMW | Protection domain of the request |
| new_addr | input | AW | Word address |
| new_mode | input | 2 | Access mode, carried unchanged |
| new_wdata | input | DW | Write data |
| mem_valid | output | 1 | Request on the memory port |
| mem_is_retry | output | 1 | Port request comes from the queue |
| mem_stream | output | SW | Stream id of port request |
| mem_domain | output | DMW | Domain of port request |
| mem_addr | output | AW | Address of port request |
| mem_mode | output | 2 | Mode of port request |
| mem_wdata | output | DW | Write data of port request |
| mem_fail | input | 1 | Same-cycle full/empty failure of the port request |
| mem_rdata | input | DW | Same-cycle read data |
| rsp_valid | output | 1 | Successful access completed |
| rsp_stream | output | SW | Stream id of the completion |
| rsp_data | output | DW | Read data of the completion |
| trap_valid | output | 1 | Retry limit reached |
| trap_stream | output | SW | Stream to trap |
| trap_domain | output | DMW | Domain of the trapping request |

## Verification
The bench targets the slot arbiter in several corners: a saturated gap counter, a gap of zero, and a full queue with a new request still offered. A design that missed the full-queue override would deadlock, since the gap counter only advances on new issues. The bench also tests limit values of 0 and 1 and a limit rewritten mid-run. An off-by-one in the count comparison would show up as one retry too many or too few before the trap. It tests queue rotation with several parked entries, where a wrong rotation would reorder retries or lose write data. It also runs a long pseudo-random phase with the failing addresses toggled, where any drift between queue pointers and occupancy would surface as a wrong stream on a response.

// File: rtl/sync_retry_queue.sv
module sync_retry_queue #(
  parameter int SW = 7,
  parameter int DMW = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int GW = 4,
  parameter int DEPTH = 16,
  parameter int LIM_RST = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [GW-1:0]  retry_gap,
  input  logic           cfg_we,
  input  logic [DMW-1:0] cfg_domain,
  input  logic [LW-1:0]  cfg_limit,
  input  logic           new_valid,
  output logic           new_ready,
  input  logic [SW-1:0]  new_stream,
  input  logic [DMW-1:0] new_domain,
  input  logic [AW-1:0]  new_addr,
  input  logic [1:0]     new_mode,
  input  logic [DW-1:0]  new_wdata,
  output logic           mem_valid,
  output logic           mem_is_retry,
  output logic [SW-1:0]  mem_stream,
  output logic [DMW-1:0] mem_domain,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_mode,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_fail,
  input  logic [DW-1:0]  mem_rdata,
  output logic           rsp_valid,
  output logic [SW-1:0]  rsp_stream,
  output logic [DW-1:0]  rsp_data,
  output logic           trap_valid,
  output logic [SW-1:0]  trap_stream,
  output logic [DMW-1:0] trap_domain
);
  localparam int ND = 1 << DMW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [SW-1:0]  q_stream [DEPTH];
  logic [DMW-1:0] q_domain [DEPTH];
  logic [AW-1:0]  q_addr   [DEPTH];
  logic [1:0]     q_mode   [DEPTH];
  logic [DW-1:0]  q_wdata  [DEPTH];
  logic [LW-1:0]  q_cnt    [DEPTH];
  logic [LW-1:0]  lim      [ND];

  logic [PW-1:0] head, tail;
  logic [OW-1:0] occ;
  logic [GW-1:0] gcnt;

  logic full, take_r, new_go, failed, hit_limit, push;
  logic [LW:0] next_cnt;

  assign full   = (occ == OW'(DEPTH));
  assign take_r = (occ != '0) && (!new_valid || gcnt >= retry_gap || full);
  assign new_ready = !full && !take_r;
  assign new_go = new_valid && new_ready;

  assign mem_valid    = take_r || new_go;
  assign mem_is_retry = take_r;
  assign mem_stream = take_r ? q_stream[head] : new_stream;
  assign mem_domain = take_r ? q_domain[head] : new_domain;
  assign mem_addr   = take_r ? q_addr[head]   : new_addr;
  assign mem_mode   = take_r ? q_mode[head]   : new_mode;
  assign mem_wdata  = take_r ? q_wdata[head]  : new_wdata;

  assign next_cnt  = take_r ? ({1'b0, q_cnt[head]} + 1'b1) : '0;
  assign hit_limit = next_cnt >= {1'b0, lim[mem_domain]};
  assign failed    = mem_valid && mem_fail;
  assign push      = failed && !hit_limit;

  assign rsp_valid   = mem_valid && !mem_fail;
  assign rsp_stream  = mem_stream;
  assign rsp_data    = mem_rdata;
  assign trap_valid  = failed && hit_limit;
  assign trap_stream = mem_stream;
  assign trap_domain = mem_domain;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
      gcnt <= '0;
    end else begin
      if (take_r) head <= bump(head);
      if (push) tail <= bump(tail);
      if (push && !take_r) occ <= occ + 1'b1;
      else if (!push && take_r) occ <= occ - 1'b1;
      if (take_r) gcnt <= '0;
      else if (new_go && gcnt != '1) gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_stream[tail] <= mem_stream;
      q_domain[tail] <= mem_domain;
      q_addr[tail]   <= mem_addr;
      q_mode[tail]   <= mem_mode;
      q_wdata[tail]  <= mem_wdata;
      q_cnt[tail]    <= next_cnt[LW-1:0];
    end
  end

  generate
    for (genvar d = 0; d < ND; d++) begin : g_lim
      always_ff @(posedge clk) begin
        if (!rst_n) lim[d] <= LW'(LIM_RST);
        else if (cfg_we && cfg_domain == DMW'(d)) lim[d] <= cfg_limit;
      end
    end
  endgenerate
endmodule

// File: rtl/sync_retry_queue_chk.sv
module sync_retry_queue_chk #(
  parameter int GW = 4,
  parameter int DEPTH = 16,
  parameter int OW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [GW-1:0] retry_gap,
  input logic          new_valid,
  input logic          new_ready,
  input logic          mem_valid,
  input logic          mem_is_retry,
  input logic          mem_fail,
  input logic          rsp_valid,
  input logic          trap_valid,
  input logic [OW-1:0] occ
);
  logic [GW-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (mem_valid && mem_is_retry) seen <= '0;
    else if (mem_valid && seen != '1) seen <= seen + 1'b1;
  end

  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(DEPTH)) |-> (!new_ready && mem_is_retry));
  // R5
  idle_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0 && !new_valid) |-> (mem_valid && mem_is_retry));
  // R4
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_is_retry && new_valid && occ != OW'(DEPTH)) |-> (seen >= retry_gap));
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, trap_valid}) && (trap_valid -> (mem_valid && mem_fail)));
  // R3
  park_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_is_retry && mem_fail && !trap_valid) |=> (occ == $past(occ) + 1'b1));
  // R1
  empty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
endmodule

bind sync_retry_queue sync_retry_queue_chk #(.GW(GW), .DEPTH(DEPTH), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retry_gap(retry_gap), .new_valid(new_valid),
  .new_ready(new_ready), .mem_valid(mem_valid), .mem_is_retry(mem_is_retry),
  .mem_fail(mem_fail), .rsp_valid(rsp_valid), .trap_valid(trap_valid), .occ(occ)
);

// File: tb/test_sync_retry_queue.sv
module test_sync_retry_queue;
  localparam int DEPTH = 16;
  localparam int GMAX = 15;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [3:0] retry_gap = 0;
  logic cfg_we = 0; logic [3:0] cfg_domain = 0; logic [7:0] cfg_limit = 0;
  logic nv = 0; logic [6:0] ns = 0; logic [3:0] nd = 0; logic [15:0] na = 0;
  logic [1:0] nm = 0; logic [15:0] nw = 0;
  logic new_ready, mem_valid, mem_is_retry, mem_fail, rsp_valid, trap_valid;
  logic [6:0] mem_stream, rsp_stream, trap_stream;
  logic [3:0] mem_domain, trap_domain;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, rsp_data;
  logic [1:0] mem_mode;
  logic [15:0] fmask = 0;

  assign mem_fail  = mem_valid && fmask[mem_addr[3:0]];
  assign mem_rdata = mem_addr ^ 16'h5a5a;

  sync_retry_queue i_sync_retry_queue (
    .clk(clk), .rst_n(rst_n), .retry_gap(retry_gap), .cfg_we(cfg_we),
    .cfg_domain(cfg_domain), .cfg_limit(cfg_limit), .new_valid(nv),
    .new_ready(new_ready), .new_stream(ns), .new_domain(nd), .new_addr(na),
    .new_mode(nm), .new_wdata(nw), .mem_valid(mem_valid), .mem_is_retry(mem_is_retry),
    .mem_stream(mem_stream), .mem_domain(mem_domain), .mem_addr(mem_addr),
    .mem_mode(mem_mode), .mem_wdata(mem_wdata), .mem_fail(mem_fail),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_stream(rsp_stream),
    .rsp_data(rsp_data), .trap_valid(trap_valid), .trap_stream(trap_stream),
    .trap_domain(trap_domain)
  );

  typedef struct {int s; int d; int a; int m; int w; int c;} ent_t;
  ent_t mq[$];
  int lim[16];
  int gcnt = 0;
  int n_chk = 0, n_err = 0;
  bit o_trap, o_rsp, o_retry;
  int o_addr;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    ent_t e;
    bit full, tr, rdy, go, f, trap;
    int nc;
    #1;
    full = mq.size() == DEPTH;
    tr = mq.size() != 0 && (!nv || gcnt >= int'(retry_gap) || full);
    rdy = !full && !tr;
    go = nv && rdy;
    chk("R10", "new_ready", new_ready, rdy);
    chk("R5", "mem_valid", mem_valid, tr || go);
    chk("R4", "mem_is_retry", mem_is_retry, tr);
    o_retry = tr; o_trap = 0; o_rsp = 0; o_addr = -1;
    if (tr || go) begin
      if (tr) e = mq.pop_front();
      else e = '{s:int'(ns), d:int'(nd), a:int'(na), m:int'(nm), w:int'(nw), c:-1};
      chk("R6", "mem_stream", mem_stream, e.s);
      chk("R6", "mem_domain", mem_domain, e.d);
      chk("R6", "mem_addr", mem_addr, e.a);
      chk("R6", "mem_mode", mem_mode, e.m);
      chk("R6", "mem_wdata", mem_wdata, e.w);
      o_addr = e.a;
      f = fmask[e.a[3:0]];
      nc = e.c + 1;
      trap = f && nc >= lim[e.d];
      chk("R8", "trap_valid", trap_valid, trap);
      chk("R7", "rsp_valid", rsp_valid, !f);
      if (!f) begin
        chk("R7", "rsp_stream", rsp_stream, e.s);
        chk("R2", "rsp_data", rsp_data, e.a ^ 'h5a5a);
      end
      if (trap) begin
        chk("R8", "trap_stream", trap_stream, e.s);
        chk("R8", "trap_domain", trap_domain, e.d);
      end else if (f) begin
        e.c = nc;
        mq.push_back(e);
      end
      o_trap = trap; o_rsp = !f;
    end else begin
      chk("R1", "rsp_valid idle", rsp_valid, 0);
      chk("R1", "trap_valid idle", trap_valid, 0);
    end
    if (tr) gcnt = 0;
    else if (go && gcnt < GMAX) gcnt++;
    if (cfg_we) lim[cfg_domain] = cfg_limit;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setlim(input int d, input int v);
    cfg_we = 1; cfg_domain = 4'(d); cfg_limit = 8'(v);
    tick();
    cfg_we = 0;
  endtask

  task automatic req(input int s, input int d, input int a);
    nv = 1; ns = 7'(s); nd = 4'(d); na = 16'(a); nm = 2'(s % 4); nw = 16'(s * 37 + a);
    tick();
    nv = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit saw;
    logic [15:0] lf;
    for (int d = 0; d < 16; d++) lim[d] = 8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "new_ready after reset", new_ready, 1);
    chk("R1", "mem_valid after reset", mem_valid, 0);
    idle(2);

    setlim(0, 3); setlim(1, 0); setlim(2, 1); setlim(3, 200);

    // limit of 3 retries with gap 2 and steady new traffic
    retry_gap = 2; fmask[3] = 1;
    req(10, 0, 3);
    chk("R3", "no trap on first failure", o_trap, 0);
    for (int i = 0; i < 12; i++) req(20 + i, 0, 0);
    idle(4);

    // parked request later succeeds
    req(11, 3, 3);
    req(40, 0, 1);
    idle(1);
    chk("R3", "parked request re-sent", o_retry && o_addr == 3, 1);
    fmask[3] = 0;
    idle(1);
    chk("R7", "retry success response", o_rsp && o_retry, 1);
    idle(2);

    // limit zero: immediate trap
    fmask[5] = 1;
    req(12, 1, 5);
    chk("R9", "immediate trap", o_trap, 1);
    idle(2);
    chk("R9", "nothing queued", o_retry, 0);

    // R11: rewrite a limit, next cycle it applies
    setlim(6, 0);
    req(13, 6, 5);
    chk("R11", "new limit applied", o_trap, 1);
    setlim(2, 1);
    req(14, 2, 5);
    idle(1);
    chk("R8", "limit one traps on first retry", o_trap && o_retry, 1);
    fmask[5] = 0;

    // fill the queue with saturated gap
    retry_gap = 15; fmask[7] = 1;
    for (int i = 0; i < 24; i++) req(50 + i, 3, 7);
    saw = 0;
    for (int i = 0; i < 6; i++) begin
      req(90 + i, 0, 0);
      if (!new_ready) saw = 1;
    end
    chk("R10", "stall seen while full", mq.size() == DEPTH, 1);
    idle(20);
    fmask[7] = 0;
    idle(30);

    // gap zero: retries take every slot
    retry_gap = 0; fmask[9] = 1;
    req(100, 0, 9);
    req(101, 2, 9);
    for (int i = 0; i < 8; i++) req(102 + i, 0, 2);
    fmask[9] = 0;
    idle(5);

    // pseudo-random traffic
    lf = 16'hace1;
    retry_gap = 1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 50 == 0) fmask = lf & 16'h0f0f;
      if (i % 97 == 0) retry_gap = lf[7:4];
      if (i % 131 == 0) begin setlim(int'(lf[3:0]), int'(lf[9:8]) * 3); end
      if (lf[0] || lf[5]) req(int'(lf[6:0]), int'(lf[11:8]) % 4, int'(lf[15:12]));
      else tick();
    end
    fmask = 0;
    idle(40);
    chk("R6", "queue drained", mq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule